// File: doc/BRIEF.md
# Converter Output Code Formatter

This block sits between the converter pipeline and the digital output pads of an imaging front end. Each clock it takes the converter code and turns it into the word that goes to the pads. The word can be plain binary or Gray code. It can also be a differential word, meaning the difference from the sample two clocks earlier. In the differential modes, the block sends two absolute reference samples after each black-pulse edge so that the receiver can rebuild the absolute values.

The coded word can have its top bit and its lower group inverted independently. During pre-blanking, the word is replaced by a programmable clamp code, and this replacement is delayed to line up with the converter pipeline. The block also produces a pad drive-enable. The pad ring uses it to float the bus when the output-enable pin disables it or when the part is in a low-power state.

Top module: `adc_code_formatter`

## Requirements
- R1: While `rst` is high, the output register holds zero. With the drive-enable asserted, `dout` reads 0 on the first clock after reset.
- R2: In binary mode (`cfg_code_mode` = 00), with no inversion and no blanking, `dout` equals the `code_in` sampled on the previous rising clock edge.
- R3: In Gray mode (`cfg_code_mode` = 01), `dout` equals `v ^ (v >> 1)`, where `v` is the sampled code.
- R4: `cfg_inv_msb` inverts only bit DATA_W-1 and `cfg_inv_low` inverts bits DATA_W-2 down to 0. With both set, every bit is inverted. Inversion is applied after coding.
- R5: In mode 10, the output is the sampled code minus the code sampled two clocks earlier, modulo 2^DATA_W. In mode 11, the output is the Gray code of that difference. The history is zero after reset.
- R6: A rising black-pulse edge can be detected at clock edge E. The words loaded on the (3+s)-th and (4+s)-th rising edges after E are then absolute samples, still Gray-coded in mode 11. Here s is `cfg_ref_sel` (0..3). All other words in the differential modes are differences.
- R7: With `cfg_align_fall` = 0, the black pulse is sampled on the rising clock edge. With `cfg_align_fall` = 1, it is first captured on the falling edge. A pulse that rises in the second half of a cycle is therefore detected one rising edge later than with rising alignment.
- R8: The blanking level sampled on a rising edge replaces the output word exactly BLANK_LAT rising edges later with the clamp code CLAMP_BASE + CLAMP_STEP × `cfg_clamp_sel`. This replacement overrides both coding and inversion.
- R9: Blanking is active when `blank_pin` XOR `cfg_blank_pol` is 1, so `cfg_blank_pol` = 1 makes the pin active-low.
- R10: `dout_en` is low, in the same cycle, whenever `oe_n`, `cfg_standby` or `cfg_sleep` is high. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | DATA_W | Converter code from the pipeline |
| blank_pin | input | 1 | Pre-blanking input pin |
| oe_n | input | 1 | Output-enable pin, high disables the bus |
| black_pulse | input | 1 | Optical-black pulse |
| cfg_standby | input | 1 | Standby state bit |
| cfg_sleep | input | 1 | Sleep state bit |
| cfg_inv_msb | input | 1 | Invert top bit |
| cfg_inv_low | input | 1 | Invert lower bits |
| cfg_code_mode | input | 2 | 00 binary, 01 Gray, 10 differential binary, 11 differential Gray |
| cfg_ref_sel | input | 2 | Reference slot pair select |
| cfg_align_fall | input | 1 | Capture the black pulse on the falling edge |
| cfg_blank_pol | input | 1 | Blanking pin active-low when 1 |
| cfg_clamp_sel | input | CLAMP_SEL_W | Clamp code step index |
| dout | output | DATA_W | Formatted output word |
| dout_en | output | 1 | Pad drive-enable, low means high impedance |

## Verification
The bench builds the block with an 8-bit code, a blanking delay of 5 and a clamp base of 8 with step 4. This keeps full 256-value sweeps of the binary and Gray coders short. It also keeps the blanking window and its exact start and end edges within a few cycles. All eight combinations of reference slot pair and black-pulse alignment are run with a pulse that rises mid-cycle. Each one shows which two differential words turn absolute, and whether falling-edge capture shifts them by one clock.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    typedef enum logic [1:0] {
        CODE_BIN       = 2'b00,
        CODE_GRAY      = 2'b01,
        CODE_DIFF_BIN  = 2'b10,
        CODE_DIFF_GRAY = 2'b11
    } code_mode_e;

    localparam int REF_BASE_SLOT = 3;
    localparam int SLOT_W        = 3;

    typedef struct packed {
        logic       inv_msb;
        logic       inv_low;
        code_mode_e mode;
        logic [1:0] ref_sel;
        logic       align_fall;
        logic       blank_pol;
    } fmt_cfg_t;

    function automatic logic mode_is_diff(code_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_is_gray(code_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/fmt_blank_delay.sv
module fmt_blank_delay #(
    parameter int LAT = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic pol,
    output logic act_out
);
    logic act_in;
    assign act_in = pin ^ pol;

    generate
        if (LAT == 1) begin : g_single
            logic sr;
            always_ff @(posedge clk) begin
                if (rst) sr <= 1'b0;
                else     sr <= act_in;
            end
            assign act_out = sr;
        end else begin : g_chain
            logic [LAT-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[LAT-2:0], act_in};
            end
            assign act_out = sr[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/fmt_ref_timer.sv
module fmt_ref_timer
    import fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       black_pulse,
    input  logic       align_fall,
    input  logic [1:0] ref_sel,
    output logic       ref_now
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = {SLOT_W{1'b1}};

    logic              bp_neg, bp_q, bp_s, bp_edge;
    logic [SLOT_W-1:0] slot_cnt, slot_lo, slot_hi;

    always_ff @(negedge clk) begin
        if (rst) bp_neg <= 1'b0;
        else     bp_neg <= black_pulse;
    end

    assign bp_s    = align_fall ? bp_neg : black_pulse;
    assign bp_edge = bp_s & ~bp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_q     <= 1'b0;
            slot_cnt <= '0;
        end else begin
            bp_q <= bp_s;
            if (bp_edge)
                slot_cnt <= SLOT_W'(1);
            else if (slot_cnt != '0)
                slot_cnt <= (slot_cnt == LAST_SLOT) ? '0 : slot_cnt + 1'b1;
        end
    end

    assign slot_lo = SLOT_W'(REF_BASE_SLOT) + SLOT_W'(ref_sel);
    assign slot_hi = slot_lo + 1'b1;
    assign ref_now = (slot_cnt == slot_lo) || (slot_cnt == slot_hi);
endmodule

// File: rtl/fmt_encoder.sv
module fmt_encoder
    import fmt_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] code,
    input  code_mode_e        mode,
    input  logic              ref_now,
    output logic [DATA_W-1:0] coded
);
    logic [DATA_W-1:0] hist1, hist2, delta, base;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist1 <= '0;
            hist2 <= '0;
        end else begin
            hist2 <= hist1;
            hist1 <= code;
        end
    end

    assign delta = code - hist2;

    always_comb begin
        base  = (mode_is_diff(mode) && !ref_now) ? delta : code;
        coded = mode_is_gray(mode) ? (base ^ (base >> 1)) : base;
    end
endmodule

// File: rtl/adc_code_formatter.sv
module adc_code_formatter
    import fmt_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int BLANK_LAT   = 12,
    parameter int CLAMP_SEL_W = 5,
    parameter int CLAMP_BASE  = 56,
    parameter int CLAMP_STEP  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [DATA_W-1:0]      code_in,
    input  logic                   blank_pin,
    input  logic                   oe_n,
    input  logic                   black_pulse,
    input  logic                   cfg_standby,
    input  logic                   cfg_sleep,
    input  logic                   cfg_inv_msb,
    input  logic                   cfg_inv_low,
    input  logic [1:0]             cfg_code_mode,
    input  logic [1:0]             cfg_ref_sel,
    input  logic                   cfg_align_fall,
    input  logic                   cfg_blank_pol,
    input  logic [CLAMP_SEL_W-1:0] cfg_clamp_sel,
    output logic [DATA_W-1:0]      dout,
    output logic                   dout_en
);
    fmt_cfg_t          cfg;
    logic              blank_act, ref_now;
    logic [DATA_W-1:0] coded, inv_mask, clamp_code, word_nx, word_q;

    always_comb begin
        cfg.inv_msb    = cfg_inv_msb;
        cfg.inv_low    = cfg_inv_low;
        cfg.mode       = code_mode_e'(cfg_code_mode);
        cfg.ref_sel    = cfg_ref_sel;
        cfg.align_fall = cfg_align_fall;
        cfg.blank_pol  = cfg_blank_pol;
    end

    fmt_blank_delay #(.LAT(BLANK_LAT)) u_blank (
        .clk(clk), .rst(rst), .pin(blank_pin), .pol(cfg.blank_pol), .act_out(blank_act)
    );

    fmt_ref_timer u_ref (
        .clk(clk), .rst(rst), .black_pulse(black_pulse),
        .align_fall(cfg.align_fall), .ref_sel(cfg.ref_sel), .ref_now(ref_now)
    );

    fmt_encoder #(.DATA_W(DATA_W)) u_enc (
        .clk(clk), .rst(rst), .code(code_in), .mode(cfg.mode),
        .ref_now(ref_now), .coded(coded)
    );

    always_comb begin
        inv_mask   = {cfg.inv_msb, {(DATA_W-1){cfg.inv_low}}};
        clamp_code = DATA_W'(CLAMP_BASE) + DATA_W'(CLAMP_STEP) * DATA_W'(cfg_clamp_sel);
        word_nx    = blank_act ? clamp_code : (coded ^ inv_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_nx;
    end

    assign dout    = word_q;
    assign dout_en = ~(oe_n | cfg_standby | cfg_sleep);
endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
    parameter int DATA_W      = 12,
    parameter int CLAMP_SEL_W = 5,
    parameter int CLAMP_BASE  = 56,
    parameter int CLAMP_STEP  = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [DATA_W-1:0]      code_in,
    input logic                   oe_n,
    input logic                   cfg_standby,
    input logic                   cfg_sleep,
    input logic                   cfg_inv_msb,
    input logic                   cfg_inv_low,
    input logic [1:0]             cfg_code_mode,
    input logic [CLAMP_SEL_W-1:0] cfg_clamp_sel,
    input logic                   blank_act,
    input logic                   ref_now,
    input logic [DATA_W-1:0]      dout,
    input logic                   dout_en
);
    logic [1:0]        age;
    logic [DATA_W-1:0] mask, clamp;

    always_ff @(posedge clk) begin
        if (rst)          age <= '0;
        else if (age < 3) age <= age + 1'b1;
    end

    assign mask  = {cfg_inv_msb, {(DATA_W-1){cfg_inv_low}}};
    assign clamp = DATA_W'(CLAMP_BASE) + DATA_W'(CLAMP_STEP) * DATA_W'(cfg_clamp_sel);

    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> dout == '0);

    p_binary_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (!blank_act && cfg_code_mode == 2'b00 && !cfg_inv_msb && !cfg_inv_low)
        |=> dout == $past(code_in));

    p_invert_after_code_r4: assert property (@(posedge clk) disable iff (rst)
        (!blank_act && cfg_code_mode == 2'b00) |=> dout == ($past(code_in) ^ $past(mask)));

    p_diff_two_back_r5: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !blank_act && !ref_now && cfg_code_mode == 2'b10
         && !cfg_inv_msb && !cfg_inv_low)
        |=> dout == DATA_W'($past(code_in) - $past(code_in, 3)));

    p_ref_pair_open_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_now) |=> ref_now);

    p_ref_pair_close_r6: assert property (@(posedge clk) disable iff (rst)
        (ref_now && $past(ref_now)) |=> !ref_now);

    p_blank_clamp_r8: assert property (@(posedge clk) disable iff (rst)
        blank_act |=> dout == $past(clamp));

    p_drive_off_r10: assert property (@(posedge clk) disable iff (rst)
        (oe_n || cfg_standby || cfg_sleep) |-> !dout_en);
endmodule

bind adc_code_formatter fmt_checker #(
    .DATA_W(DATA_W), .CLAMP_SEL_W(CLAMP_SEL_W),
    .CLAMP_BASE(CLAMP_BASE), .CLAMP_STEP(CLAMP_STEP)
) u_chk (
    .clk(clk), .rst(rst), .code_in(code_in), .oe_n(oe_n),
    .cfg_standby(cfg_standby), .cfg_sleep(cfg_sleep),
    .cfg_inv_msb(cfg_inv_msb), .cfg_inv_low(cfg_inv_low),
    .cfg_code_mode(cfg_code_mode), .cfg_clamp_sel(cfg_clamp_sel),
    .blank_act(blank_act), .ref_now(ref_now), .dout(dout), .dout_en(dout_en)
);

// File: tb/adc_code_formatter_tb.sv
module adc_code_formatter_tb;
    localparam int W    = 8;
    localparam int LAT  = 5;
    localparam int CSW  = 5;
    localparam int CB   = 8;
    localparam int CS   = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [W-1:0]   code_in = '0;
    logic           blank_pin = 1'b0, oe_n = 1'b0, black_pulse = 1'b0;
    logic           cfg_standby = 1'b0, cfg_sleep = 1'b0;
    logic           cfg_inv_msb = 1'b0, cfg_inv_low = 1'b0;
    logic [1:0]     cfg_code_mode = 2'b00, cfg_ref_sel = 2'b00;
    logic           cfg_align_fall = 1'b0, cfg_blank_pol = 1'b0;
    logic [CSW-1:0] cfg_clamp_sel = 5'd5;
    logic [W-1:0]   dout;
    logic           dout_en;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    logic [W-1:0] h1 = '0, h2 = '0;
    logic [LAT-1:0] bl = '0;
    bit exp_ref = 0;

    always #5 clk = ~clk;

    adc_code_formatter #(
        .DATA_W(W), .BLANK_LAT(LAT), .CLAMP_SEL_W(CSW),
        .CLAMP_BASE(CB), .CLAMP_STEP(CS)
    ) u_dut (
        .clk(clk), .rst(rst), .code_in(code_in), .blank_pin(blank_pin),
        .oe_n(oe_n), .black_pulse(black_pulse), .cfg_standby(cfg_standby),
        .cfg_sleep(cfg_sleep), .cfg_inv_msb(cfg_inv_msb), .cfg_inv_low(cfg_inv_low),
        .cfg_code_mode(cfg_code_mode), .cfg_ref_sel(cfg_ref_sel),
        .cfg_align_fall(cfg_align_fall), .cfg_blank_pol(cfg_blank_pol),
        .cfg_clamp_sel(cfg_clamp_sel), .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: model the expected word from the inputs before the edge,
    // then compare after the edge.
    task automatic cycle(input string req, input bit do_chk);
        logic [W-1:0] base, coded, mask, exp;
        logic use_bl;
        base   = (cfg_code_mode[1] && !exp_ref) ? W'(code_in - h2) : code_in;
        coded  = cfg_code_mode[0] ? (base ^ (base >> 1)) : base;
        mask   = {cfg_inv_msb, {(W-1){cfg_inv_low}}};
        use_bl = bl[LAT-1];
        exp    = use_bl ? W'(CB + CS * int'(cfg_clamp_sel)) : (coded ^ mask);
        bl     = {bl[LAT-2:0], blank_pin ^ cfg_blank_pol};
        h2     = h1;
        h1     = code_in;
        @(posedge clk);
        #1;
        if (do_chk) check(req, dout, exp);
    endtask

    task automatic check_en(input string req);
        bit exp;
        #1;
        exp = !(oe_n || cfg_standby || cfg_sleep);
        n_checks++;
        if (dout_en !== exp) begin
            n_fail++;
            $display("FAIL %s: actual dout_en %0b expected %0b", req, dout_en, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset clears the word even with a nonzero code present
        code_in = 8'h5A;
        repeat (3) @(posedge clk);
        #1;
        check("R1", dout, '0);
        code_in = '0;
        @(posedge clk);
        #1;
        rst = 1'b0;
        h1 = '0; h2 = '0; bl = '0;
        check("R1", dout, '0);

        // R2: binary sweep
        cfg_code_mode = 2'b00;
        for (int v = 0; v < 256; v++) begin
            code_in = W'(v);
            cycle("R2", 1);
        end

        // R3: Gray sweep
        cfg_code_mode = 2'b01;
        for (int v = 0; v < 256; v++) begin
            code_in = W'(v);
            cycle("R3", 1);
        end

        // R4: every inversion pairing, binary and Gray
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 4; k++) begin
                cfg_code_mode = 2'(m);
                cfg_inv_msb = k[1];
                cfg_inv_low = k[0];
                for (int v = 0; v < 64; v++) begin
                    code_in = W'(v * 5 + k * 13);
                    cycle("R4", 1);
                end
            end
        end
        cfg_inv_msb = 1'b0;
        cfg_inv_low = 1'b0;

        // R5: differential binary and differential Gray, including wrap-around
        for (int m = 2; m < 4; m++) begin
            cfg_code_mode = 2'(m);
            for (int v = 0; v < 96; v++) begin
                code_in = W'(v * 37 + 200);
                cycle("R5", 1);
            end
        end

        // R6 / R7: reference slot pairs, pulse rising mid-cycle
        for (int al = 0; al < 2; al++) begin
            for (int s = 0; s < 4; s++) begin
                cfg_code_mode  = 2'b10;
                cfg_align_fall = al[0];
                cfg_ref_sel    = 2'(s);
                black_pulse    = 1'b0;
                exp_ref        = 0;
                for (int j = 0; j < 10; j++) begin
                    code_in = W'(100 + 7 * j);
                    cycle("R6", 1);
                end
                #6;
                black_pulse = 1'b1;
                for (int j = 1; j <= 11; j++) begin
                    exp_ref = ((j - 1 - al) == 3 + s) || ((j - 1 - al) == 4 + s);
                    code_in = W'(30 + 11 * j);
                    cycle(al ? "R7" : "R6", 1);
                end
                exp_ref = 0;
                black_pulse = 1'b0;
                for (int j = 0; j < 4; j++) begin
                    code_in = W'(9 * j);
                    cycle("R6", 1);
                end
            end
        end
        cfg_align_fall = 1'b0;

        // R6: absolute slots stay Gray-coded in differential Gray
        cfg_code_mode = 2'b11;
        cfg_ref_sel   = 2'b01;
        for (int j = 0; j < 10; j++) begin
            code_in = W'(60 + 3 * j);
            cycle("R6", 1);
        end
        #6;
        black_pulse = 1'b1;
        for (int j = 1; j <= 10; j++) begin
            exp_ref = ((j - 1) == 4) || ((j - 1) == 5);
            code_in = W'(170 + 13 * j);
            cycle("R6", 1);
        end
        exp_ref = 0;
        black_pulse = 1'b0;
        repeat (3) cycle("R6", 1);

        // R8: blanking override with inversion active, active-high pin
        cfg_code_mode = 2'b01;
        cfg_inv_msb = 1'b1;
        cfg_inv_low = 1'b1;
        cfg_clamp_sel = 5'd5;
        for (int j = 0; j < 20; j++) begin
            blank_pin = (j >= 3 && j < 9);
            code_in = W'(j * 19 + 1);
            cycle("R8", 1);
        end
        cfg_clamp_sel = 5'd31;
        for (int j = 0; j < 14; j++) begin
            blank_pin = (j == 2);
            code_in = W'(j * 23);
            cycle("R8", 1);
        end

        // R9: active-low blanking
        cfg_blank_pol = 1'b1;
        cfg_clamp_sel = 5'd0;
        for (int j = 0; j < 20; j++) begin
            blank_pin = !(j >= 4 && j < 7);
            code_in = W'(j * 29 + 3);
            cycle("R9", 1);
        end
        blank_pin = 1'b1;
        cfg_inv_msb = 1'b0;
        cfg_inv_low = 1'b0;
        repeat (LAT + 1) cycle("R9", 1);

        // R10: drive-enable from the pin and the low-power bits
        for (int k = 0; k < 8; k++) begin
            oe_n = k[0];
            cfg_standby = k[1];
            cfg_sleep = k[2];
            check_en("R10");
        end
        oe_n = 1'b0;
        cfg_standby = 1'b0;
        cfg_sleep = 1'b0;
        check_en("R10");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule